// File: doc/BRIEF.md
# Dual-Device NOR Flash Command Sequencer

This block turns single host requests into the command-cycle sequences that a bank of parallel NOR flash needs. The command set is single-address: the command and its confirm go to the same location. The bank is two identical 16-bit devices side by side on a 32-bit bus. Every command byte is therefore sent in bits [7:0] and again in bits [23:16], with bits [15:8] and [31:24] at zero. The host can ask for five operations: program one word, erase a sector, lock a sector, unlock a sector, or query a sector's protection. The host waits for a one-cycle completion pulse that carries a two-bit result code.

Each bus access takes exactly one clock. A write cycle asserts `fl_we` with address and data. A read cycle asserts `fl_re`, and `fl_rdata` is captured at the clock edge that ends that cycle. Program and erase poll the device status once per cycle. Polling is bounded by a cycle limit taken from an input that software holds steady. Lock, unlock and query read the lock bits back through the identifier mode and check that the two devices agree.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset `req_ready` is 1, and `done`, `fl_we` and `fl_re` are 0.
- R2: A program request (op 0) whose pre-read passes issues, at the request address, the writes 0x00500050, 0x00FF00FF, 0x00400040 and then the data word. After polling completes, it writes 0x00500050 and 0x00FF00FF.
- R3: Before programming, the word at the target is read. If (contents AND data) differs from data, the request ends with code 2 and issues no write cycle.
- R4: An erase request (op 1) writes 0x00500050, 0x00200020 and 0x00D000D0 to the sector base. The sector base is the address with its low SECT_BITS bits cleared. After polling completes, the erase writes 0x00FF00FF.
- R5: Polling reads the target once per cycle. It completes only on a read where bit 7 and bit 23 are both 1, and a clean completion gives code 0.
- R6: With limit L, at most L poll reads are made. If the L-th read is still not ready, the block writes 0x00B000B0, then the normal closing writes, and reports code 1. A ready status on the L-th read still counts as success.
- R7: A program whose final status has bit 4 or bit 20 set reports code 1.
- R8: Lock (op 2) writes 0x00FF00FF, 0x00600060, 0x00010001, 0x00FF00FF and 0x00900090 to the sector base. Unlock (op 3) sends the same writes but with 0x00D000D0 in place of 0x00010001. Both then read base+2 and write 0x00FF00FF. The code is 0 when the readback shows the requested state.
- R9: A readback masked by 0x00010001 is read as follows: 0x00010001 means locked and 0 means unlocked. Any other value is a mixed state, which reports code 1 with `locked` = 1.
- R10: A query (op 4) writes 0x00900090 to the sector base, reads base+2, then writes 0x00FF00FF. It returns `locked` as in R9, with code 0 unless the state is mixed.
- R11: `req_ready` is low from the cycle after acceptance until `done`. `done` is a single-cycle pulse. Ops 5 to 7 complete with code 1 and no bus cycle.
- R12: `fl_we` and `fl_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_op | input | 3 | 0 program, 1 erase, 2 lock, 3 unlock, 4 query |
| req_addr | input | AW | Word address (target or any word of the sector) |
| req_data | input | 32 | Word to program |
| tmo_limit | input | TW | Maximum number of poll reads |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 OK, 1 timeout/failure, 2 not erased |
| locked | output | 1 | Lock readback for ops 2 to 4, valid with done |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | 32 | Flash write data |
| fl_we | output | 1 | Flash write cycle |
| fl_re | output | 1 | Flash read cycle |
| fl_rdata | input | 32 | Flash read data |

## Verification
Two events can land on the same poll read: the device turning ready, and the poll count reaching its limit. The bench provokes this by setting a limit of four with a modelled program latency of three cycles, so that the fourth and final allowed read is the first one to return ready. The request must then end with code 0 and no suspend write. With the latency raised by one cycle, the same fourth read is still busy, and the bench expects 0x00B000B0 as the fifth write and code 1.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int AW        = 20,
  parameter int SECT_BITS = 8,
  parameter int TW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_data,
  input  logic [TW-1:0] tmo_limit,
  output logic          done,
  output logic [1:0]    result,
  output logic          locked,
  output logic [AW-1:0] fl_addr,
  output logic [31:0]   fl_wdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic [31:0]   fl_rdata
);
  localparam logic [2:0] OP_PROG   = 3'd0;
  localparam logic [2:0] OP_ERASE  = 3'd1;
  localparam logic [2:0] OP_LOCK   = 3'd2;
  localparam logic [2:0] OP_UNLOCK = 3'd3;
  localparam logic [2:0] OP_QUERY  = 3'd4;
  localparam logic [31:0] LOCK_MASK = 32'h0001_0001;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SETUP, S_POLL, S_SUSP, S_IDRD, S_TAIL, S_FIN} st_t;

  st_t           st;
  logic [2:0]    op_q, step, nsteps;
  logic [AW-1:0] tgt;
  logic [31:0]   dat, cmd;
  logic [TW-1:0] tcnt;
  logic [TW:0]   tnext;
  logic          err_q, lock_q, done_q, last;
  logic [1:0]    res_q;
  logic          rdy, pfail, rb_lock, rb_mixed;
  logic [31:0]   rb;

  function automatic logic [31:0] rep(input logic [7:0] b);
    return {8'h00, b, 8'h00, b};
  endfunction

  always_comb begin
    cmd    = rep(8'hFF);
    nsteps = 3'd1;
    if (st == S_SETUP) begin
      case (op_q)
        OP_PROG: begin
          nsteps = 3'd4;
          case (step)
            3'd0:    cmd = rep(8'h50);
            3'd1:    cmd = rep(8'hFF);
            3'd2:    cmd = rep(8'h40);
            default: cmd = dat;
          endcase
        end
        OP_ERASE: begin
          nsteps = 3'd3;
          case (step)
            3'd0:    cmd = rep(8'h50);
            3'd1:    cmd = rep(8'h20);
            default: cmd = rep(8'hD0);
          endcase
        end
        OP_LOCK, OP_UNLOCK: begin
          nsteps = 3'd5;
          case (step)
            3'd0:    cmd = rep(8'hFF);
            3'd1:    cmd = rep(8'h60);
            3'd2:    cmd = (op_q == OP_LOCK) ? rep(8'h01) : rep(8'hD0);
            3'd3:    cmd = rep(8'hFF);
            default: cmd = rep(8'h90);
          endcase
        end
        default: cmd = rep(8'h90);
      endcase
    end else if (st == S_TAIL && op_q == OP_PROG) begin
      nsteps = 3'd2;
      cmd    = (step == 3'd0) ? rep(8'h50) : rep(8'hFF);
    end else if (st == S_SUSP) begin
      cmd = rep(8'hB0);
    end
  end

  assign last      = (step == nsteps - 3'd1);
  assign fl_we     = (st == S_SETUP) || (st == S_SUSP) || (st == S_TAIL);
  assign fl_re     = (st == S_PRE) || (st == S_POLL) || (st == S_IDRD);
  assign fl_addr   = (st == S_IDRD) ? (tgt | AW'(2)) : tgt;
  assign fl_wdata  = fl_we ? cmd : 32'h0;
  assign req_ready = (st == S_IDLE);
  assign done      = done_q;
  assign result    = res_q;
  assign locked    = lock_q;

  assign rdy      = fl_rdata[7] & fl_rdata[23];
  assign pfail    = fl_rdata[4] | fl_rdata[20];
  assign rb       = fl_rdata & LOCK_MASK;
  assign rb_lock  = (rb != 32'h0);
  assign rb_mixed = rb_lock && (rb != LOCK_MASK);
  assign tnext    = {1'b0, tcnt} + {{TW{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= 3'd0;
      step   <= 3'd0;
      tgt    <= '0;
      dat    <= 32'h0;
      tcnt   <= '0;
      err_q  <= 1'b0;
      lock_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= 2'd0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q   <= req_op;
          dat    <= req_data;
          step   <= 3'd0;
          tcnt   <= '0;
          err_q  <= 1'b0;
          lock_q <= 1'b0;
          tgt    <= (req_op == OP_PROG) ? req_addr
                                        : {req_addr[AW-1:SECT_BITS], {SECT_BITS{1'b0}}};
          if (req_op == OP_PROG) st <= S_PRE;
          else if (req_op <= OP_QUERY) st <= S_SETUP;
          else begin
            res_q <= 2'd1;
            st    <= S_FIN;
          end
        end
        S_PRE: begin
          if ((fl_rdata & dat) != dat) begin
            res_q <= 2'd2;
            st    <= S_FIN;
          end else st <= S_SETUP;
        end
        S_SETUP: begin
          if (last) begin
            step <= 3'd0;
            st   <= (op_q <= OP_ERASE) ? S_POLL : S_IDRD;
          end else step <= step + 3'd1;
        end
        S_POLL: begin
          if (rdy) begin
            err_q <= err_q | ((op_q == OP_PROG) & pfail);
            st    <= S_TAIL;
          end else if (tnext >= {1'b0, tmo_limit}) begin
            err_q <= 1'b1;
            st    <= S_SUSP;
          end else tcnt <= tnext[TW-1:0];
        end
        S_SUSP: st <= S_TAIL;
        S_IDRD: begin
          lock_q <= rb_lock;
          err_q  <= rb_mixed || (op_q == OP_LOCK && !rb_lock) ||
                    (op_q == OP_UNLOCK && rb_lock);
          st     <= S_TAIL;
        end
        S_TAIL: begin
          if (last) begin
            step   <= 3'd0;
            res_q  <= err_q ? 2'd1 : 2'd0;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else step <= step + 3'd1;
        end
        default: begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic        fl_we,
  input logic        fl_re,
  input logic [31:0] fl_wdata
);
  p_bus_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_no_bus_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || fl_re) |-> !req_ready);

  p_write_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && $past(fl_re)) |->
      (fl_wdata == 32'h00B0_00B0 || fl_wdata == 32'h0050_0050 || fl_wdata == 32'h00FF_00FF));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .fl_we(fl_we), .fl_re(fl_re), .fl_wdata(fl_wdata)
);

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [15:0] tmo = 16'd20;
  logic        done, locked;
  logic [1:0]  result;
  logic [19:0] fl_addr;
  logic [31:0] fl_wdata, fl_rdata;
  logic        fl_we, fl_re;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .tmo_limit(tmo),
    .done(done), .result(result), .locked(locked), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
  );

  // flash bank model: two devices, one status/lock bit per half
  logic [31:0] mem [1024];
  logic [19:0] wa [256];
  logic [31:0] wd [256];
  logic        llo [4];
  logic        lhi [4];
  int nw = 0, nrd = 0, busy = 0, pend = 0, mode = 0;
  logic sfail = 1'b0;
  int prog_lat = 3, erase_lat = 5;
  logic inject_fail = 1'b0, stuck_hi = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 1024; k++) mem[k] <= 32'hFFFF_FFFF;
      for (int k = 0; k < 4; k++) begin llo[k] <= 1'b0; lhi[k] <= 1'b0; end
      busy <= 0; pend <= 0; mode <= 0; sfail <= 1'b0;
    end else begin
      if (busy > 0) busy <= busy - 1;
      if (fl_re) nrd <= nrd + 1;
      if (fl_we) begin
        wa[nw[7:0]] <= fl_addr;
        wd[nw[7:0]] <= fl_wdata;
        nw <= nw + 1;
        if (pend == 1) begin
          mem[fl_addr[9:0]] <= mem[fl_addr[9:0]] & fl_wdata;
          busy <= prog_lat; sfail <= inject_fail; pend <= 0; mode <= 1;
        end else if (pend == 2) begin
          pend <= 0; mode <= 1;
          if (fl_wdata[7:0] == 8'hD0) begin
            for (int k = 0; k < 256; k++) mem[{fl_addr[9:8], 8'(k)}] <= 32'hFFFF_FFFF;
            busy <= erase_lat;
          end
        end else if (pend == 3) begin
          pend <= 0;
          if (fl_wdata[7:0] == 8'h01) begin
            llo[fl_addr[9:8]] <= 1'b1;
            if (!stuck_hi) lhi[fl_addr[9:8]] <= 1'b1;
          end else if (fl_wdata[7:0] == 8'hD0) begin
            llo[fl_addr[9:8]] <= 1'b0;
            if (!stuck_hi) lhi[fl_addr[9:8]] <= 1'b0;
          end
        end else begin
          case (fl_wdata[7:0])
            8'h50: sfail <= 1'b0;
            8'hFF: mode <= 0;
            8'h40: begin pend <= 1; mode <= 1; end
            8'h20: begin pend <= 2; mode <= 1; end
            8'h60: pend <= 3;
            8'h90: mode <= 2;
            8'hB0: mode <= 1;
            default: ;
          endcase
        end
      end
    end
  end

  logic [15:0] sthalf;
  assign sthalf = {8'h00, (busy == 0), 2'b00, sfail, 4'h0};
  always_comb begin
    case (mode)
      0:       fl_rdata = mem[fl_addr[9:0]];
      1:       fl_rdata = {sthalf, sthalf};
      default: fl_rdata = (fl_addr[7:0] == 8'd2) ?
                 {15'h0, lhi[fl_addr[9:8]], 15'h0, llo[fl_addr[9:8]]} : 32'h0;
    endcase
  end

  int checks = 0, errors = 0;
  int wb = 0, rb = 0;
  logic [1:0] r_code;
  logic r_lock;
  logic finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_w(input string tag, input int idx, input logic [19:0] a, input logic [31:0] d);
    chk({tag, " addr"}, 32'(wa[(wb + idx) % 256]), 32'(a));
    chk({tag, " data"}, wd[(wb + idx) % 256], d);
  endtask

  task automatic issue(input logic [2:0] op, input logic [19:0] a, input logic [31:0] d);
    int n;
    @(negedge clk);
    wb = nw; rb = nrd;
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 ready low while busy", 32'(req_ready), 32'd0);
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    r_code = result; r_lock = locked;
    @(negedge clk);
    chk("R11 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 we", 32'(fl_we), 32'd0);
    chk("R1 re", 32'(fl_re), 32'd0);
  endtask

  task automatic t_program;
    prog_lat = 3; tmo = 16'd20;
    issue(3'd0, 20'h010, 32'h1234_5678);
    chk("R5 code ok", 32'(r_code), 32'd0);
    chk("R2 writes", 32'(nw - wb), 32'd6);
    chk_w("R2 w0", 0, 20'h010, 32'h0050_0050);
    chk_w("R2 w1", 1, 20'h010, 32'h00FF_00FF);
    chk_w("R2 w2", 2, 20'h010, 32'h0040_0040);
    chk_w("R2 w3", 3, 20'h010, 32'h1234_5678);
    chk_w("R2 w4", 4, 20'h010, 32'h0050_0050);
    chk_w("R2 w5", 5, 20'h010, 32'h00FF_00FF);
    chk("R5 read count", 32'(nrd - rb), 32'(prog_lat + 2));
    chk("R2 stored", mem[10'h010], 32'h1234_5678);
    issue(3'd0, 20'h010, 32'h1234_0000);
    chk("R3 subset accepted", 32'(r_code), 32'd0);
  endtask

  task automatic t_not_erased;
    issue(3'd0, 20'h010, 32'hFFFF_0000);
    chk("R3 code", 32'(r_code), 32'd2);
    chk("R3 no writes", 32'(nw - wb), 32'd0);
  endtask

  task automatic t_erase;
    erase_lat = 5; tmo = 16'd20;
    issue(3'd1, 20'h013, 32'h0);
    chk("R4 code", 32'(r_code), 32'd0);
    chk("R4 writes", 32'(nw - wb), 32'd4);
    chk_w("R4 w0", 0, 20'h000, 32'h0050_0050);
    chk_w("R4 w1", 1, 20'h000, 32'h0020_0020);
    chk_w("R4 w2", 2, 20'h000, 32'h00D0_00D0);
    chk_w("R4 w3", 3, 20'h000, 32'h00FF_00FF);
    chk("R4 erased", mem[10'h010], 32'hFFFF_FFFF);
  endtask

  task automatic t_prog_fail;
    inject_fail = 1'b1; prog_lat = 2; tmo = 16'd20;
    issue(3'd0, 20'h030, 32'h0000_00AA);
    inject_fail = 1'b0;
    chk("R7 code", 32'(r_code), 32'd1);
    chk("R7 writes", 32'(nw - wb), 32'd6);
  endtask

  task automatic t_timeout;
    tmo = 16'd4;
    prog_lat = 3;
    issue(3'd0, 20'h020, 32'h0F0F_0F0F);
    chk("R6 ready on last read", 32'(r_code), 32'd0);
    chk("R6 no suspend", 32'(nw - wb), 32'd6);
    chk("R6 poll reads", 32'(nrd - rb), 32'd5);
    prog_lat = 4;
    issue(3'd0, 20'h021, 32'h0F0F_0F0F);
    chk("R6 timeout code", 32'(r_code), 32'd1);
    chk("R6 timeout writes", 32'(nw - wb), 32'd7);
    chk_w("R6 suspend", 4, 20'h021, 32'h00B0_00B0);
    chk_w("R6 tail", 5, 20'h021, 32'h0050_0050);
    erase_lat = 10;
    issue(3'd1, 20'h300, 32'h0);
    chk("R6 erase timeout code", 32'(r_code), 32'd1);
    chk("R6 erase writes", 32'(nw - wb), 32'd5);
    chk_w("R6 erase suspend", 3, 20'h300, 32'h00B0_00B0);
    tmo = 16'd20;
  endtask

  task automatic t_lock;
    issue(3'd2, 20'h155, 32'h0);
    chk("R8 lock code", 32'(r_code), 32'd0);
    chk("R8 lock state", 32'(r_lock), 32'd1);
    chk("R8 writes", 32'(nw - wb), 32'd6);
    chk_w("R8 w0", 0, 20'h100, 32'h00FF_00FF);
    chk_w("R8 w1", 1, 20'h100, 32'h0060_0060);
    chk_w("R8 w2", 2, 20'h100, 32'h0001_0001);
    chk_w("R8 w3", 3, 20'h100, 32'h00FF_00FF);
    chk_w("R8 w4", 4, 20'h100, 32'h0090_0090);
    chk_w("R8 w5", 5, 20'h100, 32'h00FF_00FF);
    issue(3'd4, 20'h1F0, 32'h0);
    chk("R10 query locked", 32'(r_lock), 32'd1);
    chk("R10 query code", 32'(r_code), 32'd0);
    chk("R10 writes", 32'(nw - wb), 32'd2);
    chk_w("R10 w0", 0, 20'h100, 32'h0090_0090);
    chk_w("R10 w1", 1, 20'h100, 32'h00FF_00FF);
    issue(3'd3, 20'h100, 32'h0);
    chk("R8 unlock code", 32'(r_code), 32'd0);
    chk("R8 unlock state", 32'(r_lock), 32'd0);
    chk_w("R8 unlock cmd", 2, 20'h100, 32'h00D0_00D0);
    issue(3'd4, 20'h101, 32'h0);
    chk("R10 query unlocked", 32'(r_lock), 32'd0);
  endtask

  task automatic t_mixed;
    stuck_hi = 1'b1;
    issue(3'd2, 20'h2A0, 32'h0);
    chk("R9 mixed code", 32'(r_code), 32'd1);
    chk("R9 mixed locked", 32'(r_lock), 32'd1);
    issue(3'd4, 20'h200, 32'h0);
    chk("R9 query mixed code", 32'(r_code), 32'd1);
    chk("R9 query mixed locked", 32'(r_lock), 32'd1);
    stuck_hi = 1'b0;
  endtask

  task automatic t_bad_op;
    issue(3'd7, 20'h000, 32'h0);
    chk("R11 bad op code", 32'(r_code), 32'd1);
    chk("R11 bad op no writes", 32'(nw - wb), 32'd0);
    chk("R11 bad op no reads", 32'(nrd - rb), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_not_erased();
    t_erase();
    t_prog_fail();
    t_timeout();
    t_lock();
    t_mixed();
    t_bad_op();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule